// File: doc/BRIEF.md
# Calendar Alarm Match and Event Flag Unit

This block watches a running calendar time (minute, hour, day of month and day of week, each as a 7-bit BCD value) and raises an alarm flag when every armed alarm field agrees with the current time. The comparison runs only on cycles where the time-update strobe is high. The flag is set only when the time enters a matching state, not on each cycle that the state holds.

A small register port gives software access to the alarm fields, a control register and a status register. The status register holds the alarm flag and four event flags that other units set through single-cycle pulses. Software clears flags by AND-on-write, so writing 1 to a flag bit leaves that flag unchanged. An active-low interrupt output follows the alarm flag while the alarm interrupt is enabled.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, each alarm register reads 0x80, the status and control registers read 0x00, `alarm_flag_o` is 0 and `irq_no` is 1.
- R2: The register map is as follows. Address 0 is control, with bit 0 as the alarm interrupt enable and all other bits reading 0. Address 1 is status. Addresses 2, 3, 4 and 5 are the minute, hour, day and weekday alarms. In each alarm register, bit 7 is an active-low enable (1 means the field is disabled) and bits 6:0 hold the BCD value to compare.
- R3: A field takes part in the match only when its bit 7 is 0. A field with bit 7 set to 1 is ignored. If all four fields are disabled, the alarm never triggers.
- R4: On a strobe cycle where all enabled fields equal the current time, and the previous strobe did not match, the alarm flag (status bit 3) is 1 after that clock edge. Time inputs that change without a strobe never set the flag.
- R5: After a software clear, the flag stays 0 while the matching time is strobed again. It sets again only after a strobe with no match is followed by a strobe that matches.
- R6: Once set, the alarm flag stays 1 through further strobes until software clears it.
- R7: A status write ANDs bits 7:3 with their current values. A 0 clears a flag and a 1 leaves it unchanged. Bits 2:0 take the written value.
- R8: A pulse on `evt_set_i` bits 3, 2, 1 and 0 sets status bits 7, 6, 5 and 4 respectively.
- R9: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: `irq_no` is 0 exactly when the interrupt enable is 1 and the alarm flag is 1. It returns high on the edge that clears the flag, and it stays high while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-update strobe, one cycle |
| cur_min_i | input | 7 | Current minute, BCD |
| cur_hour_i | input | 7 | Current hour, BCD |
| cur_day_i | input | 7 | Current day of month, BCD |
| cur_wday_i | input | 7 | Current weekday |
| evt_set_i | input | 4 | Event flag set pulses for status bits 7:4 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| alarm_flag_o | output | 1 | Alarm flag level |
| irq_no | output | 1 | Alarm interrupt, active low |

## Verification
Within a single cycle, a hardware flag set can coincide with a software status write that clears the same flag. The bench forces this case twice. First, it pulses an event input in the same cycle as a write that clears that event's bit. Second, it strobes a newly matching time in the same cycle as a write that clears the alarm flag. In both cases the flag must read back as 1 afterwards. Neighbouring flags must keep the values that the AND rule gives them.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned FIELD_N = 4;
  localparam int unsigned VAL_W   = 7;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned EVT_N   = 4;
  localparam int unsigned FLAG_N  = EVT_N + 1;
  localparam int unsigned MISC_W  = DATA_W - FLAG_N;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ALM0 = 3'd2;

  typedef struct packed {
    logic             off;
    logic [VAL_W-1:0] val;
  } alarm_field_t;

  localparam alarm_field_t FIELD_RST = '{off: 1'b1, val: '0};
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned N_FIELDS = FIELD_N
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output alarm_field_t [N_FIELDS-1:0] fields_o,
  output logic                      irq_en_o,
  output logic [MISC_W-1:0]         misc_o,
  output logic                      stat_wr_o
);
  assign stat_wr_o = wr_en_i && (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o <= 1'b0;
      misc_o   <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_CTRL) irq_en_o <= wdata_i[0];
      if (stat_wr_o) misc_o <= wdata_i[MISC_W-1:0];
    end
  end

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fields_o[g] <= FIELD_RST;
      else if (wr_en_i && addr_i == ADDR_W'(ADDR_ALM0 + g))
        fields_o[g] <= alarm_field_t'(wdata_i);
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned N_FIELDS = FIELD_N
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [N_FIELDS-1:0][VAL_W-1:0] cur_i,
  input  alarm_field_t [N_FIELDS-1:0]   fields_i,
  output logic                          set_o
);
  logic [N_FIELDS-1:0] hit, armed;
  logic match_now, match_prev;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_cmp
    assign armed[g] = ~fields_i[g].off;
    assign hit[g]   = fields_i[g].off | (fields_i[g].val == cur_i[g]);
  end

  // all-disabled never matches
  assign match_now = (&hit) & (|armed);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     match_prev <= 1'b0;
    else if (tick_i) match_prev <= match_now;
  end

  assign set_o = tick_i & match_now & ~match_prev;
endmodule

// File: rtl/flag_unit.sv
module flag_unit #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] kept;
  assign kept = clr_wr_i ? (flags_o & keep_i) : flags_o;

  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= kept | set_i;
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [VAL_W-1:0]  cur_min_i,
  input  logic [VAL_W-1:0]  cur_hour_i,
  input  logic [VAL_W-1:0]  cur_day_i,
  input  logic [VAL_W-1:0]  cur_wday_i,
  input  logic [EVT_N-1:0]  evt_set_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              alarm_flag_o,
  output logic              irq_no
);
  alarm_field_t [FIELD_N-1:0]        fields;
  logic [FIELD_N-1:0][VAL_W-1:0]     cur;
  logic                              irq_en, stat_wr, alm_set;
  logic [MISC_W-1:0]                 misc;
  logic [FLAG_N-1:0]                 flags;

  assign cur = {cur_wday_i, cur_day_i, cur_hour_i, cur_min_i};

  alarm_regs #(.N_FIELDS(FIELD_N)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .fields_o(fields), .irq_en_o(irq_en), .misc_o(misc), .stat_wr_o(stat_wr)
  );

  alarm_match #(.N_FIELDS(FIELD_N)) u_match (
    .clk_i, .rst_ni, .tick_i, .cur_i(cur), .fields_i(fields), .set_o(alm_set)
  );

  // flags[0] = alarm (status bit 3), flags[4:1] = events (status bits 7:4)
  flag_unit #(.N(FLAG_N)) u_flags (
    .clk_i, .rst_ni,
    .set_i({evt_set_i, alm_set}),
    .clr_wr_i(stat_wr),
    .keep_i(wdata_i[DATA_W-1:MISC_W]),
    .flags_o(flags)
  );

  assign alarm_flag_o = flags[0];
  assign irq_no       = ~(irq_en & flags[0]);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL)      rdata_o[0] = irq_en;
    else if (addr_i == ADDR_STAT) rdata_o = {flags, misc};
    else begin
      for (int i = 0; i < FIELD_N; i++)
        if (addr_i == ADDR_W'(ADDR_ALM0 + i)) rdata_o = DATA_W'(fields[i]);
    end
  end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic set_pulse,
  input logic af,
  input logic irq_no,
  input logic ie,
  input logic stat_wr,
  input logic keep_af
);
  // R4: flag only rises after a match pulse
  a_r4_rise_from_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af) |-> $past(set_pulse));
  // R9
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pulse |=> af);
  // R6
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    af && !(stat_wr && !keep_af) |=> af);
  // R7
  a_r7_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr && !keep_af && !set_pulse |=> !af);
  // R10
  a_r10_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> irq_no);
  a_r10_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !af |-> irq_no);
endmodule

bind rtc_alarm_unit rtc_alarm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_pulse(alm_set), .af(alarm_flag_o),
  .irq_no(irq_no), .ie(irq_en), .stat_wr(stat_wr), .keep_af(wdata_i[3])
);

// File: tb/tb_rtc_alarm_unit.sv
module tb_rtc_alarm_unit;
  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_en_i = 1'b0;
  logic [6:0] cur_min_i = '0, cur_hour_i = '0, cur_day_i = '0, cur_wday_i = '0;
  logic [3:0] evt_set_i = '0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic alarm_flag_o, irq_no;
  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  rtc_alarm_unit dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    addr_i = a; #1 d = rdata_o;
  endtask

  task automatic tick(logic [6:0] m, logic [6:0] h, logic [6:0] dy, logic [6:0] wd);
    @(negedge clk_i);
    cur_min_i = m; cur_hour_i = h; cur_day_i = dy; cur_wday_i = wd; tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic chk_stat(string req, logic [7:0] exp);
    logic [7:0] d;
    rd(3'd1, d); chk(req, d, exp);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 2; a < 6; a++) begin rd(3'(a), d); chk("R1 alarm reg", d, 8'h80); end
    rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
    chk_stat("R1 status", 8'h00);
    chk("R1 flag", {7'd0, alarm_flag_o}, 8'h0);
    chk("R1 irq", {7'd0, irq_no}, 8'h1);
  endtask

  task automatic t_all_disabled;
    tick(7'h00, 7'h00, 7'h00, 7'h00);
    chk("R3 all disabled no set", {7'd0, alarm_flag_o}, 8'h0);
  endtask

  task automatic t_minute_match;
    logic [7:0] d;
    wr(3'd2, 8'h30);
    rd(3'd2, d); chk("R2 minute reg", d, 8'h30);
    tick(7'h29, 7'h05, 7'h01, 7'h02);
    chk("R4 mismatch", {7'd0, alarm_flag_o}, 8'h0);
    tick(7'h30, 7'h05, 7'h01, 7'h02);
    chk("R4 match sets", {7'd0, alarm_flag_o}, 8'h1);
    chk("R10 irq masked", {7'd0, irq_no}, 8'h1);
    chk_stat("R2 status bit3", 8'h08);
  endtask

  task automatic t_irq_enable;
    wr(3'd0, 8'h01);
    chk("R10 irq asserted", {7'd0, irq_no}, 8'h0);
  endtask

  task automatic t_clear_rearm;
    wr(3'd1, 8'hF7);
    chk_stat("R7 clear af, misc written", 8'h07);
    chk("R10 irq drops with clear", {7'd0, irq_no}, 8'h1);
    tick(7'h30, 7'h05, 7'h01, 7'h02);
    chk("R5 held match no reset", {7'd0, alarm_flag_o}, 8'h0);
    tick(7'h31, 7'h05, 7'h01, 7'h02);
    chk("R5 leave match", {7'd0, alarm_flag_o}, 8'h0);
    tick(7'h30, 7'h05, 7'h01, 7'h02);
    chk("R5 re-enter match", {7'd0, alarm_flag_o}, 8'h1);
    chk("R10 irq again", {7'd0, irq_no}, 8'h0);
  endtask

  task automatic t_sticky;
    tick(7'h45, 7'h05, 7'h01, 7'h02);
    tick(7'h46, 7'h05, 7'h01, 7'h02);
    chk("R6 sticky", {7'd0, alarm_flag_o}, 8'h1);
    wr(3'd1, 8'hFF);
    chk_stat("R7 ones keep flags", 8'h0F);
  endtask

  task automatic t_no_tick;
    wr(3'd1, 8'hF0);
    chk_stat("R7 clear all", 8'h00);
    @(negedge clk_i); cur_min_i = 7'h30;
    repeat (3) @(negedge clk_i);
    chk("R4 no strobe no set", {7'd0, alarm_flag_o}, 8'h0);
  endtask

  task automatic t_multi_field;
    wr(3'd3, 8'h12);
    wr(3'd5, 8'h86);
    tick(7'h30, 7'h11, 7'h01, 7'h02);
    chk("R3 hour mismatch", {7'd0, alarm_flag_o}, 8'h0);
    tick(7'h31, 7'h12, 7'h01, 7'h02);
    chk("R3 minute mismatch", {7'd0, alarm_flag_o}, 8'h0);
    tick(7'h30, 7'h12, 7'h01, 7'h02);
    chk("R3 both match, weekday ignored", {7'd0, alarm_flag_o}, 8'h1);
    chk_stat("R3 status", 8'h08);
  endtask

  task automatic t_events;
    @(negedge clk_i); evt_set_i = 4'b1010;
    @(negedge clk_i); evt_set_i = 4'b0000;
    chk_stat("R8 events set bits 7,5", 8'hA8);
    wr(3'd1, 8'h7F);
    chk_stat("R7 clear bit7 only", 8'h2F);
  endtask

  task automatic t_set_wins;
    @(negedge clk_i);
    evt_set_i = 4'b0001; wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 8'hEF;
    @(negedge clk_i); evt_set_i = '0; wr_en_i = 1'b0;
    chk_stat("R9 event set beats clear", 8'h3F);
    wr(3'd1, 8'hF7);
    chk_stat("R7 clear af", 8'h37);
    tick(7'h00, 7'h12, 7'h01, 7'h02);
    @(negedge clk_i);
    cur_min_i = 7'h30; tick_i = 1'b1;
    wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 8'hF7;
    @(negedge clk_i); tick_i = 1'b0; wr_en_i = 1'b0;
    chk("R9 alarm set beats clear", {7'd0, alarm_flag_o}, 8'h1);
    chk_stat("R9 status", 8'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_all_disabled;
    t_minute_match;
    t_irq_enable;
    t_clear_rearm;
    t_sticky;
    t_no_tick;
    t_multi_field;
    t_events;
    t_set_wins;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule